// File: doc/BRIEF.md
# Privilege-Checked Interrupt Controller Register Bank

This block is the memory-mapped register file of a nested vectored interrupt controller. It sits on a simple 32-bit register bus whose requests carry a 12-bit offset, write data, a byte-size code, a write strobe and a flag that marks the access as unprivileged. It holds enable, pending and priority state for each external interrupt, system-handler priority bytes, and a software trigger register that marks an interrupt pending by index. Active state comes in from the exception logic, and the bus can read it but not write it.

Every access is checked for privilege. An unprivileged access is refused with an error response, and it leaves the state unchanged and returns no data. The only exception is the software trigger register, which unprivileged code may use when a configuration input allows it. The enable, pending and priority vectors go out to a separate arbiter, which picks the highest-priority interrupt. Each request gets its response one cycle later.

Top module: `intc_priv_regs`

## Requirements
- R1: An unprivileged access (req_user=1) at any offset other than 0xF00 returns rsp_err=1 with rsp_rdata=0 and changes no enable, pending, interrupt priority or handler priority state.
- R2: An unprivileged access at offset 0xF00 completes without error when user_trig_en=1 and returns the error response when user_trig_en=0.
- R3: A write of size code 2 (4 bytes) to 0xF00 takes req_wdata[8:0] as an interrupt index n and sets pending bit n (exception number n+16) only when n < NUM_IRQ. Reads of 0xF00 return zero.
- R4: A word write to window 0x100-0x13F sets, and to 0x180-0x1BF clears, each enable bit whose data bit is 1. Word w of a window covers interrupts 32w to 32w+31, and reads of either window return the current enable bits.
- R5: Windows 0x200-0x23F and 0x280-0x2BF set and clear pending bits with the same word layout, and reads of either window return the current pending bits.
- R6: Window 0x300-0x33F reads the irq_active input in the same word layout. Writes to it complete without error and change nothing.
- R7: Byte 0x400+k holds the 8-bit priority of interrupt k. A write with size code 0, 1 or 2 updates 1, 2 or 4 consecutive bytes starting at the request offset, with byte i taken from req_wdata[8i+7:8i]. A read returns the bytes at offsets a to a+3 in lanes 0 to 3.
- R8: Offsets 0xD18-0xD23 hold system-handler priority bytes for handler index offset-0xD14 (4 to 15). They use the same size and lane rules as R7, and sys_prio byte j carries handler j+4.
- R9: A write with size code other than 2 to the enable, pending or trigger registers completes without error and has no effect.
- R10: A privileged read of an unimplemented offset returns zero without error, and a privileged write to one has no effect.
- R11: Enable, pending, active and priority state for interrupt indices at or above NUM_IRQ reads as zero and ignores writes.
- R12: rsp_ready pulses high exactly one cycle after each cycle with req_valid=1 and is low otherwise. rsp_err is never set for a privileged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Access is unprivileged |
| req_size | input | 2 | Byte count code: 0 = 1, 1 = 2, 2 = 4 |
| req_addr | input | 12 | Byte offset in the register block |
| req_wdata | input | 32 | Write data, least significant byte first |
| user_trig_en | input | 1 | Allows unprivileged use of the trigger register |
| irq_active | input | NUM_IRQ | Active state from the exception logic |
| rsp_ready | output | 1 | Response pulse |
| rsp_err | output | 1 | Error response for a refused access |
| rsp_rdata | output | 32 | Read data |
| irq_enable | output | NUM_IRQ | Enable bits to the arbiter |
| irq_pending | output | NUM_IRQ | Pending bits to the arbiter |
| irq_prio | output | NUM_IRQ*8 | Priority byte k at bits 8k+7:8k |
| sys_prio | output | 96 | Handler priority byte j (handler j+4) at bits 8j+7:8j |

## Verification
The hardest case to reach from the ports is the interaction between the privilege gate and the trigger decode: an unprivileged trigger write must be refused while user_trig_en is low and must set a pending bit once it is high, and a narrow trigger write or an index at or above NUM_IRQ must be dropped even though the access itself is allowed. The bench builds a known pending pattern through the privileged set and clear windows first. It then changes user_trig_en between directed accesses and reads the pending word back through the bus and at the pending port, so that every refused or dropped trigger shows up as an unchanged value. With NUM_IRQ set to 40, the second word of every window is only partly implemented, so the zero fill above the last interrupt is checked as well.

// File: rtl/intc_priv_regs.sv
`timescale 1ns/1ps
module intc_priv_regs #(
  parameter int NUM_IRQ = 32,
  localparam int SYS_N = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_user,
  input  logic [1:0]           req_size,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic                 user_trig_en,
  input  logic [NUM_IRQ-1:0]   irq_active,
  output logic                 rsp_ready,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_IRQ-1:0]   irq_enable,
  output logic [NUM_IRQ-1:0]   irq_pending,
  output logic [NUM_IRQ*8-1:0] irq_prio,
  output logic [SYS_N*8-1:0]   sys_prio
);
  localparam int PRIO_BASE = 'h400;
  localparam int PRIO_LAST = 'h5EF;
  localparam int SYS_BASE  = 'hD18;
  localparam int TRIG_OFF  = 'hF00;

  logic [7:0] prio_q [NUM_IRQ];
  logic [7:0] sysp_q [SYS_N];
  logic [NUM_IRQ-1:0] en_q, pd_q, lane_bits, trig_hit;
  logic [NUM_IRQ-1:0] prio_we;
  logic [7:0]         prio_wd [NUM_IRQ];
  logic [SYS_N-1:0]   sys_we;
  logic [7:0]         sys_wd [SYS_N];
  logic [31:0]        rd;
  int                 nbytes;

  wire [5:0] blk    = req_addr[11:6];
  wire [3:0] word   = req_addr[5:2];
  wire       wide   = (req_size == 2'd2);
  wire       en_set = (blk == 6'h04);
  wire       en_clr = (blk == 6'h06);
  wire       pd_set = (blk == 6'h08);
  wire       pd_clr = (blk == 6'h0A);
  wire       act_w  = (blk == 6'h0C);
  wire       in_pr  = (int'(req_addr) >= PRIO_BASE) && (int'(req_addr) <= PRIO_LAST);
  wire       in_sys = (int'(req_addr) >= SYS_BASE) && (int'(req_addr) < SYS_BASE + SYS_N);
  wire       trig   = (int'(req_addr) == TRIG_OFF);
  wire       deny   = req_user && !(trig && user_trig_en);
  wire       wr     = req_valid && req_write && !deny;

  assign nbytes = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      lane_bits[i] = (i / 32 == int'(word)) && req_wdata[i % 32];
      trig_hit[i]  = (int'(req_wdata[8:0]) == i);
      prio_we[i]   = wr && in_pr && (i + PRIO_BASE >= int'(req_addr))
                     && (i + PRIO_BASE < int'(req_addr) + nbytes);
      prio_wd[i]   = req_wdata[8*((i + PRIO_BASE - int'(req_addr)) & 3) +: 8];
    end
    for (int j = 0; j < SYS_N; j++) begin
      sys_we[j] = wr && in_sys && (j + SYS_BASE >= int'(req_addr))
                  && (j + SYS_BASE < int'(req_addr) + nbytes);
      sys_wd[j] = req_wdata[8*((j + SYS_BASE - int'(req_addr)) & 3) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      pd_q <= '0;
    end else if (wr && wide) begin
      if (en_set) en_q <= en_q | lane_bits;
      if (en_clr) en_q <= en_q & ~lane_bits;
      if (pd_set) pd_q <= pd_q | lane_bits;
      if (pd_clr) pd_q <= pd_q & ~lane_bits;
      if (trig)   pd_q <= pd_q | trig_hit;
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[k] <= '0;
      else if (prio_we[k]) prio_q[k] <= prio_wd[k];
    end
    assign irq_prio[8*k +: 8] = prio_q[k];
  end

  for (genvar j = 0; j < SYS_N; j++) begin : g_sys
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sysp_q[j] <= '0;
      else if (sys_we[j]) sysp_q[j] <= sys_wd[j];
    end
    assign sys_prio[8*j +: 8] = sysp_q[j];
  end

  function automatic logic [31:0] pick(input logic [NUM_IRQ-1:0] v, input logic [3:0] w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++)
      if (32 * int'(w) + b < NUM_IRQ) r[b] = v[32 * int'(w) + b];
    return r;
  endfunction

  always_comb begin
    rd = '0;
    if (en_set || en_clr) rd = pick(en_q, word);
    if (pd_set || pd_clr) rd = pick(pd_q, word);
    if (act_w)            rd = pick(irq_active, word);
    for (int b = 0; b < 4; b++) begin
      if (in_pr && int'(req_addr) + b - PRIO_BASE < NUM_IRQ && int'(req_addr) + b <= PRIO_LAST)
        rd[8*b +: 8] = prio_q[(int'(req_addr) + b - PRIO_BASE) % NUM_IRQ];
      if (in_sys && int'(req_addr) + b - SYS_BASE < SYS_N)
        rd[8*b +: 8] = sysp_q[(int'(req_addr) + b - SYS_BASE) % SYS_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_err   <= req_valid && deny;
      rsp_rdata <= (req_valid && !req_write && !deny) ? rd : '0;
    end
  end

  assign irq_enable  = en_q;
  assign irq_pending = pd_q;

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  p_priv_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user) |=> !rsp_err);
  p_deny_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && int'(req_addr) != TRIG_OFF) |=>
      (rsp_err && rsp_rdata == '0 && $stable(irq_enable) && $stable(irq_pending)
       && $stable(irq_prio) && $stable(sys_prio)));
  p_trig_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && int'(req_addr) == TRIG_OFF) |=>
      (rsp_err == !$past(user_trig_en)));
  p_active_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_user && req_addr[11:6] == 6'h0C) |=>
      (!rsp_err && $stable(irq_enable) && $stable(irq_pending)));
  p_narrow_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != 2'd2 &&
     (req_addr[11:9] == 3'b001 || int'(req_addr) == TRIG_OFF)) |=>
      ($stable(irq_enable) && $stable(irq_pending)));
endmodule

// File: tb/tb_intc_priv_regs.sv
`timescale 1ns/1ps
module tb_intc_priv_regs;
  localparam int N = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic user_trig_en = 1'b0;
  logic [N-1:0] irq_active = '0;
  logic rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic [N-1:0] irq_enable, irq_pending;
  logic [N*8-1:0] irq_prio;
  logic [95:0] sys_prio;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  intc_priv_regs #(.NUM_IRQ(N)) dut (.*);

  typedef struct packed {
    logic wr; logic usr; logic [1:0] sz; logic [11:0] addr;
    logic [31:0] wd; logic eerr; logic [31:0] erd; logic [7:0] rq;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,2'd2,12'h100,32'h80000011,1'b0,32'h0,8'd4},        // R4 set
    '{1'b0,1'b0,2'd2,12'h180,32'h0,1'b0,32'h80000011,8'd4},        // R4 read via clear window
    '{1'b1,1'b0,2'd2,12'h104,32'hFFFFFFFF,1'b0,32'h0,8'd11},       // R11 partial word
    '{1'b0,1'b0,2'd2,12'h104,32'h0,1'b0,32'h000000FF,8'd11},       // R11
    '{1'b1,1'b0,2'd2,12'h184,32'h000000F0,1'b0,32'h0,8'd4},        // R4 clear
    '{1'b0,1'b0,2'd2,12'h104,32'h0,1'b0,32'h0000000F,8'd4},
    '{1'b1,1'b0,2'd2,12'h180,32'h00000001,1'b0,32'h0,8'd4},
    '{1'b0,1'b0,2'd2,12'h100,32'h0,1'b0,32'h80000010,8'd4},
    '{1'b1,1'b0,2'd1,12'h100,32'h0000FFFF,1'b0,32'h0,8'd9},        // R9 narrow
    '{1'b0,1'b0,2'd2,12'h100,32'h0,1'b0,32'h80000010,8'd9},
    '{1'b1,1'b0,2'd2,12'h200,32'h000000A5,1'b0,32'h0,8'd5},        // R5
    '{1'b1,1'b0,2'd2,12'h280,32'h00000005,1'b0,32'h0,8'd5},
    '{1'b0,1'b0,2'd2,12'h200,32'h0,1'b0,32'h000000A0,8'd5},
    '{1'b0,1'b0,2'd2,12'h280,32'h0,1'b0,32'h000000A0,8'd5},
    '{1'b1,1'b0,2'd2,12'h300,32'hFFFFFFFF,1'b0,32'h0,8'd6},        // R6
    '{1'b0,1'b0,2'd2,12'h300,32'h0,1'b0,32'h0,8'd6},
    '{1'b0,1'b0,2'd2,12'h200,32'h0,1'b0,32'h000000A0,8'd6},
    '{1'b1,1'b0,2'd2,12'h400,32'h44332211,1'b0,32'h0,8'd7},        // R7
    '{1'b1,1'b0,2'd0,12'h405,32'h000000AB,1'b0,32'h0,8'd7},
    '{1'b1,1'b0,2'd1,12'h406,32'h0000CDEF,1'b0,32'h0,8'd7},
    '{1'b0,1'b0,2'd2,12'h404,32'h0,1'b0,32'hCDEFAB00,8'd7},
    '{1'b0,1'b0,2'd2,12'h400,32'h0,1'b0,32'h44332211,8'd7},
    '{1'b0,1'b0,2'd2,12'h402,32'h0,1'b0,32'hAB004433,8'd7},
    '{1'b1,1'b0,2'd2,12'h424,32'h99887766,1'b0,32'h0,8'd7},
    '{1'b1,1'b0,2'd2,12'h428,32'h12345678,1'b0,32'h0,8'd11},
    '{1'b0,1'b0,2'd2,12'h424,32'h0,1'b0,32'h99887766,8'd7},
    '{1'b0,1'b0,2'd2,12'h428,32'h0,1'b0,32'h0,8'd11},
    '{1'b1,1'b0,2'd2,12'hD18,32'h40302010,1'b0,32'h0,8'd8},        // R8
    '{1'b1,1'b0,2'd0,12'hD23,32'h0000005A,1'b0,32'h0,8'd8},
    '{1'b0,1'b0,2'd2,12'hD18,32'h0,1'b0,32'h40302010,8'd8},
    '{1'b0,1'b0,2'd2,12'hD20,32'h0,1'b0,32'h5A000000,8'd8},
    '{1'b0,1'b0,2'd2,12'hD22,32'h0,1'b0,32'h00005A00,8'd8},
    '{1'b1,1'b0,2'd2,12'h010,32'hFFFFFFFF,1'b0,32'h0,8'd10},       // R10
    '{1'b0,1'b0,2'd2,12'hE00,32'h0,1'b0,32'h0,8'd10},
    '{1'b0,1'b1,2'd2,12'h100,32'h0,1'b1,32'h0,8'd1},               // R1
    '{1'b1,1'b1,2'd2,12'h100,32'hFFFFFFFF,1'b1,32'h0,8'd1},
    '{1'b1,1'b1,2'd2,12'hF00,32'h00000003,1'b1,32'h0,8'd2}         // R2 gate closed
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic u, input logic [1:0] s,
                        input logic [11:0] a, input logic [31:0] d,
                        output logic e, output logic [31:0] r, output logic rdy);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_user = u; req_size = s;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    rdy = rsp_ready; e = rsp_err; r = rsp_rdata;
    req_valid = 1'b0;
  endtask

  logic e, rdy;
  logic [31:0] r;
  string tag;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset ready", 64'(rsp_ready), 64'd0);
    chk("R4 reset enable", 64'(irq_enable), 64'd0);
    chk("R5 reset pending", 64'(irq_pending), 64'd0);
    chk("R7 reset prio", 64'(irq_prio[63:0]), 64'd0);
    access(1'b0, 1'b0, 2'd2, 12'h400, 32'h0, e, r, rdy);
    chk("R7 reset read", 64'(r), 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].usr, VEC[i].sz, VEC[i].addr, VEC[i].wd, e, r, rdy);
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      chk({tag, " ready"}, 64'(rdy), 64'd1);
      chk({tag, " err"}, 64'(e), 64'(VEC[i].eerr));
      chk({tag, " data"}, 64'(r), 64'(VEC[i].erd));
    end

    access(1'b0, 1'b0, 2'd2, 12'h100, 32'h0, e, r, rdy);
    chk("R1 enable unchanged after refused write", 64'(r), 64'h80000010);
    access(1'b0, 1'b0, 2'd2, 12'h200, 32'h0, e, r, rdy);
    chk("R2 pending unchanged after refused trigger", 64'(r), 64'hA0);

    user_trig_en = 1'b1;
    access(1'b1, 1'b1, 2'd2, 12'hF00, 32'h3, e, r, rdy);
    chk("R2 user trigger allowed", 64'(e), 64'd0);
    access(1'b0, 1'b0, 2'd2, 12'h200, 32'h0, e, r, rdy);
    chk("R3 user trigger sets bit 3", 64'(r), 64'hA8);
    access(1'b1, 1'b0, 2'd2, 12'hF00, 32'h21, e, r, rdy);
    access(1'b0, 1'b0, 2'd2, 12'h204, 32'h0, e, r, rdy);
    chk("R3 trigger index 33", 64'(r), 64'h2);
    access(1'b1, 1'b0, 2'd2, 12'hF00, 32'h28, e, r, rdy);
    access(1'b1, 1'b0, 2'd2, 12'hF00, 32'h1FF, e, r, rdy);
    access(1'b0, 1'b0, 2'd2, 12'h204, 32'h0, e, r, rdy);
    chk("R3 out-of-range index ignored", 64'(r), 64'h2);
    access(1'b1, 1'b0, 2'd1, 12'hF00, 32'h0, e, r, rdy);
    chk("R9 narrow trigger no error", 64'(e), 64'd0);
    access(1'b0, 1'b0, 2'd2, 12'h200, 32'h0, e, r, rdy);
    chk("R9 narrow trigger ignored", 64'(r), 64'hA8);
    access(1'b0, 1'b1, 2'd2, 12'hF00, 32'h0, e, r, rdy);
    chk("R3 user trigger read err", 64'(e), 64'd0);
    chk("R3 trigger reads zero", 64'(r), 64'd0);
    access(1'b0, 1'b1, 2'd2, 12'hD18, 32'h0, e, r, rdy);
    chk("R1 user read still refused", 64'(e), 64'd1);
    chk("R1 refused read data", 64'(r), 64'd0);

    irq_active = {1'b1, 37'd0, 2'b11};
    access(1'b0, 1'b0, 2'd2, 12'h300, 32'h0, e, r, rdy);
    chk("R6 active word0", 64'(r), 64'h3);
    access(1'b0, 1'b0, 2'd2, 12'h304, 32'h0, e, r, rdy);
    chk("R6 R11 active word1", 64'(r), 64'h80);
    @(negedge clk);
    chk("R12 ready low when idle", 64'(rsp_ready), 64'd0);

    chk("R4 enable port", 64'(irq_enable), 64'h0F_8000_0010);
    chk("R5 pending port", 64'(irq_pending), 64'h02_0000_00A8);
    chk("R7 prio byte 5 port", 64'(irq_prio[5*8 +: 8]), 64'hAB);
    chk("R8 handler 4 port", 64'(sys_prio[7:0]), 64'h10);
    chk("R8 handler 15 port", 64'(sys_prio[95:88]), 64'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule